// File: doc/BRIEF.md
# Register-Driven AUX Request Engine

This block runs one AUX-side request at a time on behalf of a host processor. The host writes a command code, a 20-bit target address, a byte count and up to sixteen payload bytes into a small register file. It then sets a start bit. The engine offers the request on a valid/ready handshake toward an AUX channel model and waits for that model's reply. From the reply it updates the status flags, writes back the byte count after a partial transfer, stores any bytes that a read returned, and clears the start bit. A completion interrupt is raised when the host has enabled it.

The command code passes through to the channel unchanged. The block itself decodes only bit 0, which marks a read. The codes used in practice are:

- I2C write: 0x0
- I2C read: 0x1
- Write with the I2C transaction kept open afterwards: 0x4
- Read with the I2C transaction kept open afterwards: 0x5

A byte count of zero makes an address-only request. This is how the host opens or closes an I2C transaction. The host register port is a plain single-cycle write strobe with a combinational read-back.

Top module: `auxreq_csr_engine`

Register offsets on `hst_addr`:

| Offset | Contents |
|---|---|
| 0x00 | Command, 4 bits |
| 0x01 | Address bits 7:0 |
| 0x02 | Address bits 15:8 |
| 0x03 | Address bits 19:16 |
| 0x04 | Byte count |
| 0x05 | Start bit in bit 0 |
| 0x06 | Status: bit 0 done, bit 1 address-NACK failure, bit 2 short transfer |
| 0x07 | Interrupt configuration: bit 0 done-interrupt enable, bit 1 global interrupt enable |
| 0x10 + i | Payload byte i |
| 0x20 + i | Returned byte i (read only) |

Reply codes on `rsp_code`: 0 is ACK, 1 is NACK.

## Requirements
- R1: After reset, the command, address, count, start bit, status flags, interrupt enables and returned bytes read back as 0. Also after reset, `irq`, `req_valid` and `rsp_ready` are 0.
- R2: While `req_valid` is high, the request carries the programmed values. `req_cmd` is the command register and `req_addr` is the address assembled from offsets 0x01 to 0x03. `req_len` is the count, and byte i of `req_data` is payload byte i, starting from payload byte 0.
- R3: Writing 1 to bit 0 of offset 0x05 starts exactly one request. `req_valid` stays high until `req_ready` is seen. `rsp_ready` is high only while the engine waits for the reply. The start bit reads 0 once the reply has been taken.
- R4: When the reply is taken, status bit 0 (done) is set. For a read command (command bit 0 = 1), returned bytes 0 to count−1 are stored from `rsp_data`. Returned bytes at or above the count keep their old value.
- R5: A NACK reply with a count of 0 sets status bit 1 (address failure), and the byte count register keeps its value.
- R6: A NACK reply with a nonzero count sets status bit 2 (short transfer) and overwrites the byte count register with the reply count.
- R7: `irq` is high exactly when the done flag, the done-interrupt enable (offset 0x07 bit 0) and the global enable (offset 0x07 bit 1) are all set.
- R8: While the start bit is set, host writes to the command, address, count, payload and start registers have no effect.
- R9: Writing 1 to a status bit clears it. If the engine sets a flag in the same cycle as a host clear of that flag, the flag stays set.
- R10: Writing a value above 16 to the count register stores 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 6 | Host register offset |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data (combinational from `hst_addr`) |
| irq | output | 1 | Completion interrupt |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted by the channel |
| req_cmd | output | 4 | Request command code |
| req_addr | output | 20 | Request target address |
| req_len | output | 5 | Request byte count |
| req_data | output | 128 | Payload, byte i in bits 8i+7:8i |
| rsp_valid | input | 1 | Reply present |
| rsp_ready | output | 1 | Engine waiting for a reply |
| rsp_code | input | 2 | Reply status, 0 ACK, 1 NACK |
| rsp_count | input | 5 | Bytes completed |
| rsp_data | input | 128 | Returned bytes, byte i in bits 8i+7:8i |

## Verification
The assertions assume the channel model behaves in three ways:

- It raises `rsp_valid` only while `rsp_ready` is high.
- It never reports more completed bytes than were requested, so the count written back after a short transfer equals `rsp_count` as given.
- It accepts a request only after the request has been offered.

The stimulus keeps to all three. The bench model waits for `req_valid` before it pulses `req_ready`, and it drives a reply only in the following cycle, once `rsp_ready` is high. Every reply count in the vector table is no larger than the programmed count.

// File: rtl/auxreq_pkg.sv
package auxreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } aux_state_e;

  localparam logic [1:0] RSP_ACK  = 2'd0;
  localparam logic [1:0] RSP_NACK = 2'd1;

  localparam logic [5:0] OFS_CMD  = 6'h00;
  localparam logic [5:0] OFS_AD0  = 6'h01;
  localparam logic [5:0] OFS_AD1  = 6'h02;
  localparam logic [5:0] OFS_AD2  = 6'h03;
  localparam logic [5:0] OFS_LEN  = 6'h04;
  localparam logic [5:0] OFS_CTL  = 6'h05;
  localparam logic [5:0] OFS_STS  = 6'h06;
  localparam logic [5:0] OFS_CFG  = 6'h07;
  localparam logic [1:0] BANK_WD  = 2'b01;
  localparam logic [1:0] BANK_RD  = 2'b10;

  // smaller of a value and a limit
  function automatic logic [7:0] clamp_u8(input logic [7:0] v, input logic [7:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  // outcome of a reply: {short, fail}
  function automatic logic [1:0] classify(input logic [1:0] code, input logic nonzero);
    if (code == RSP_NACK) return nonzero ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  function automatic logic is_read(input logic [3:0] cmd);
    return cmd[0];
  endfunction

endpackage

// File: rtl/auxreq_regs.sv
module auxreq_regs
  import auxreq_pkg::*;
#(
  parameter int NBYTES = 16,
  parameter int ADDR_W = 20,
  parameter int CMD_W  = 4,
  localparam int LEN_W = $clog2(NBYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hst_wr,
  input  logic [5:0]            hst_addr,
  input  logic [7:0]            hst_wdata,
  output logic [7:0]            hst_rdata,
  input  logic                  fin_evt,
  input  logic                  fin_fail,
  input  logic                  fin_short,
  input  logic [LEN_W-1:0]      fin_count,
  input  logic [NBYTES*8-1:0]   rd_flat,
  output logic                  send_q,
  output logic [CMD_W-1:0]      cmd_q,
  output logic [ADDR_W-1:0]     addr_q,
  output logic [LEN_W-1:0]      len_q,
  output logic [NBYTES*8-1:0]   wd_flat,
  output logic                  sts_done,
  output logic                  sts_fail,
  output logic                  sts_short,
  output logic                  irq
);

  logic open_wr;
  logic cfg_done_ie, cfg_irq_en;
  logic hit_cmd, hit_ad0, hit_ad1, hit_ad2, hit_len, hit_ctl, hit_sts, hit_cfg;
  logic [2:0] sts_clr;

  assign open_wr = hst_wr && !send_q;
  assign hit_cmd = open_wr && (hst_addr == OFS_CMD);
  assign hit_ad0 = open_wr && (hst_addr == OFS_AD0);
  assign hit_ad1 = open_wr && (hst_addr == OFS_AD1);
  assign hit_ad2 = open_wr && (hst_addr == OFS_AD2);
  assign hit_len = open_wr && (hst_addr == OFS_LEN);
  assign hit_ctl = open_wr && (hst_addr == OFS_CTL);
  assign hit_sts = hst_wr && (hst_addr == OFS_STS);
  assign hit_cfg = hst_wr && (hst_addr == OFS_CFG);
  assign sts_clr = hit_sts ? hst_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end else begin
      if (hit_cmd) cmd_q <= hst_wdata[CMD_W-1:0];
      if (hit_ad0) addr_q[7:0] <= hst_wdata;
      if (hit_ad1) addr_q[15:8] <= hst_wdata;
      if (hit_ad2) addr_q[ADDR_W-1:16] <= hst_wdata[ADDR_W-17:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (fin_short) begin
      len_q <= fin_count;
    end else if (hit_len) begin
      len_q <= LEN_W'(clamp_u8(hst_wdata, 8'(NBYTES)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_q <= 1'b0;
    end else if (fin_evt) begin
      send_q <= 1'b0;
    end else if (hit_ctl && hst_wdata[0]) begin
      send_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_done  <= 1'b0;
      sts_fail  <= 1'b0;
      sts_short <= 1'b0;
    end else begin
      sts_done  <= (sts_done  && !sts_clr[0]) || fin_evt;
      sts_fail  <= (sts_fail  && !sts_clr[1]) || fin_fail;
      sts_short <= (sts_short && !sts_clr[2]) || fin_short;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done_ie <= 1'b0;
      cfg_irq_en  <= 1'b0;
    end else if (hit_cfg) begin
      cfg_done_ie <= hst_wdata[0];
      cfg_irq_en  <= hst_wdata[1];
    end
  end

  assign irq = sts_done && cfg_done_ie && cfg_irq_en;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_wd
      logic hit_wd;
      assign hit_wd = open_wr && (hst_addr == 6'(16 + gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_flat[gi*8 +: 8] <= 8'h00;
        else if (hit_wd) wd_flat[gi*8 +: 8] <= hst_wdata;
      end
    end
  endgenerate

  always_comb begin
    int idx;
    idx = int'(hst_addr[3:0]);
    hst_rdata = 8'h00;
    case (hst_addr)
      OFS_CMD: hst_rdata = 8'(cmd_q);
      OFS_AD0: hst_rdata = addr_q[7:0];
      OFS_AD1: hst_rdata = addr_q[15:8];
      OFS_AD2: hst_rdata = 8'(addr_q >> 16);
      OFS_LEN: hst_rdata = 8'(len_q);
      OFS_CTL: hst_rdata = {7'd0, send_q};
      OFS_STS: hst_rdata = {5'd0, sts_short, sts_fail, sts_done};
      OFS_CFG: hst_rdata = {6'd0, cfg_irq_en, cfg_done_ie};
      default: begin
        if (idx < NBYTES) begin
          if (hst_addr[5:4] == BANK_WD) hst_rdata = wd_flat[idx*8 +: 8];
          else if (hst_addr[5:4] == BANK_RD) hst_rdata = rd_flat[idx*8 +: 8];
        end
      end
    endcase
  end

endmodule

// File: rtl/auxreq_ctl.sv
module auxreq_ctl
  import auxreq_pkg::*;
#(
  parameter int NBYTES = 16,
  parameter int CMD_W  = 4,
  localparam int LEN_W = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_q,
  input  logic [CMD_W-1:0] cmd_q,
  input  logic [LEN_W-1:0] len_q,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_code,
  input  logic [LEN_W-1:0] rsp_count,
  output logic             req_valid,
  output logic             rsp_ready,
  output logic             fin_evt,
  output logic             fin_fail,
  output logic             fin_short,
  output logic [LEN_W-1:0] fin_count,
  output logic             rd_store
);

  aux_state_e state_q, state_d;
  logic [1:0] outcome;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (send_q) state_d = ST_REQ;
      ST_REQ:  if (req_ready) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_valid = (state_q == ST_REQ);
  assign rsp_ready = (state_q == ST_WAIT);
  assign fin_evt   = rsp_ready && rsp_valid;
  assign fin_count = LEN_W'(clamp_u8(8'(rsp_count), 8'(len_q)));
  assign outcome   = classify(rsp_code, fin_count != '0);
  assign fin_fail  = fin_evt && outcome[0];
  assign fin_short = fin_evt && outcome[1];
  assign rd_store  = fin_evt && is_read(4'(cmd_q));

endmodule

// File: rtl/auxreq_rdbuf.sv
module auxreq_rdbuf #(
  parameter int NBYTES = 16,
  localparam int LEN_W = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_store,
  input  logic [LEN_W-1:0]    fin_count,
  input  logic [NBYTES*8-1:0] rsp_data,
  output logic [NBYTES*8-1:0] rd_flat
);

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_rd
      logic take;
      assign take = rd_store && (int'(fin_count) > gi);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rd_flat[gi*8 +: 8] <= 8'h00;
        else if (take) rd_flat[gi*8 +: 8] <= rsp_data[gi*8 +: 8];
      end
    end
  endgenerate

endmodule

// File: rtl/auxreq_csr_engine.sv
module auxreq_csr_engine #(
  parameter int NBYTES = 16,
  parameter int ADDR_W = 20,
  parameter int CMD_W  = 4,
  localparam int LEN_W = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_wr,
  input  logic [5:0]          hst_addr,
  input  logic [7:0]          hst_wdata,
  output logic [7:0]          hst_rdata,
  output logic                irq,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [CMD_W-1:0]    req_cmd,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [LEN_W-1:0]    req_len,
  output logic [NBYTES*8-1:0] req_data,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [1:0]          rsp_code,
  input  logic [LEN_W-1:0]    rsp_count,
  input  logic [NBYTES*8-1:0] rsp_data
);

  logic                send_q;
  logic [CMD_W-1:0]    cmd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LEN_W-1:0]    len_q;
  logic [NBYTES*8-1:0] wd_flat;
  logic [NBYTES*8-1:0] rd_flat;
  logic                fin_evt, fin_fail, fin_short, rd_store;
  logic [LEN_W-1:0]    fin_count;
  logic                sts_done, sts_fail, sts_short;

  auxreq_regs #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .fin_evt(fin_evt), .fin_fail(fin_fail), .fin_short(fin_short), .fin_count(fin_count),
    .rd_flat(rd_flat),
    .send_q(send_q), .cmd_q(cmd_q), .addr_q(addr_q), .len_q(len_q), .wd_flat(wd_flat),
    .sts_done(sts_done), .sts_fail(sts_fail), .sts_short(sts_short), .irq(irq)
  );

  auxreq_ctl #(.NBYTES(NBYTES), .CMD_W(CMD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .send_q(send_q), .cmd_q(cmd_q), .len_q(len_q),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_count(rsp_count),
    .req_valid(req_valid), .rsp_ready(rsp_ready),
    .fin_evt(fin_evt), .fin_fail(fin_fail), .fin_short(fin_short),
    .fin_count(fin_count), .rd_store(rd_store)
  );

  auxreq_rdbuf #(.NBYTES(NBYTES)) u_rdbuf (
    .clk(clk), .rst_n(rst_n),
    .rd_store(rd_store), .fin_count(fin_count), .rsp_data(rsp_data),
    .rd_flat(rd_flat)
  );

  assign req_cmd  = cmd_q;
  assign req_addr = addr_q;
  assign req_len  = len_q;
  assign req_data = wd_flat;

endmodule

// File: rtl/auxreq_checker.sv
module auxreq_checker #(
  parameter int NBYTES = 16,
  parameter int ADDR_W = 20,
  parameter int CMD_W  = 4,
  localparam int LEN_W = $clog2(NBYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_code,
  input logic [LEN_W-1:0]  rsp_count,
  input logic              send_q,
  input logic              fin_evt,
  input logic [CMD_W-1:0]  cmd_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [LEN_W-1:0]  len_q,
  input logic              sts_done,
  input logic              sts_fail,
  input logic              sts_short,
  input logic              irq
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);

  assert_req_needs_send_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> send_q);

  assert_phases_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);

  assert_done_and_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> sts_done && !send_q);

  assert_addr_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt && rsp_code == 2'd1 && rsp_count == '0 |=> sts_fail);

  assert_short_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt && rsp_code == 2'd1 && rsp_count != '0 |=> sts_short && len_q == $past(rsp_count));

  assert_irq_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts_done);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    send_q |=> $stable(cmd_q) && $stable(addr_q));

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    send_q && !fin_evt |=> $stable(len_q));

endmodule

bind auxreq_csr_engine auxreq_checker #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_code(rsp_code), .rsp_count(rsp_count),
  .send_q(send_q), .fin_evt(fin_evt),
  .cmd_q(cmd_q), .addr_q(addr_q), .len_q(len_q),
  .sts_done(sts_done), .sts_fail(sts_fail), .sts_short(sts_short),
  .irq(irq)
);

// File: tb/auxreq_csr_engine_bench.sv
`timescale 1ns/1ps
module auxreq_csr_engine_bench;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        hst_wr = 1'b0;
  logic [5:0]  hst_addr = '0;
  logic [7:0]  hst_wdata = '0;
  logic [7:0]  hst_rdata;
  logic        irq, req_valid, rsp_ready;
  logic        req_ready = 1'b0;
  logic [3:0]  req_cmd;
  logic [19:0] req_addr;
  logic [4:0]  req_len;
  logic [NB*8-1:0] req_data;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_code = '0;
  logic [4:0]  rsp_count = '0;
  logic [NB*8-1:0] rsp_data = '0;

  auxreq_csr_engine u_auxreq_csr_engine (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .irq(irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_len(req_len), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_count(rsp_count), .rsp_data(rsp_data)
  );

  int errs = 0;
  int checks = 0;

  // cmd, len, code, count, expected status, expected len
  localparam logic [23:0] VEC [6] = '{
    {4'h4, 5'd0,  2'd0, 5'd0,  3'b001, 5'd0},
    {4'h4, 5'd1,  2'd0, 5'd1,  3'b001, 5'd1},
    {4'h5, 5'd16, 2'd0, 5'd16, 3'b001, 5'd16},
    {4'h1, 5'd0,  2'd1, 5'd0,  3'b011, 5'd0},
    {4'h5, 5'd8,  2'd1, 5'd3,  3'b101, 5'd3},
    {4'h0, 5'd4,  2'd0, 5'd4,  3'b001, 5'd4}
  };

  logic [3:0]  cap_cmd;
  logic [4:0]  cap_len;
  logic [19:0] cap_addr;
  logic [NB*8-1:0] cap_data;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hread(input logic [5:0] a, output logic [7:0] d);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  function automatic logic [NB*8-1:0] mk_data(input logic [7:0] seed);
    logic [NB*8-1:0] r;
    for (int j = 0; j < NB; j++) r[j*8 +: 8] = seed + 8'(j);
    return r;
  endfunction

  task automatic serve(input logic [1:0] code, input logic [4:0] count,
                       input logic [7:0] seed, input bit clr_same);
    forever begin
      @(negedge clk);
      if (req_valid) break;
    end
    cap_cmd = req_cmd; cap_len = req_len; cap_addr = req_addr; cap_data = req_data;
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk("R3 rsp_ready while waiting", {31'd0, rsp_ready}, 32'd1);
    chk("R3 req_valid dropped after accept", {31'd0, req_valid}, 32'd0);
    rsp_valid = 1'b1; rsp_code = code; rsp_count = count; rsp_data = mk_data(seed);
    if (clr_same) begin
      hst_wr = 1'b1; hst_addr = 6'h06; hst_wdata = 8'h07;
    end
    @(negedge clk);
    rsp_valid = 1'b0;
    hst_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(6'h06, rv); chk("R1 status after reset", {24'd0, rv}, 32'h0);
    hread(6'h05, rv); chk("R1 start bit after reset", {24'd0, rv}, 32'h0);
    hread(6'h04, rv); chk("R1 count after reset", {24'd0, rv}, 32'h0);
    hread(6'h00, rv); chk("R1 command after reset", {24'd0, rv}, 32'h0);
    hread(6'h07, rv); chk("R1 irq config after reset", {24'd0, rv}, 32'h0);
    hread(6'h25, rv); chk("R1 returned byte after reset", {24'd0, rv}, 32'h0);
    chk("R1 irq/req_valid/rsp_ready after reset", {29'd0, irq, req_valid, rsp_ready}, 32'h0);

    // R10 clamp
    hwrite(6'h04, 8'd20);
    hread(6'h04, rv); chk("R10 count clamped to 16", {24'd0, rv}, 32'd16);

    hwrite(6'h02, 8'h12);
    hwrite(6'h03, 8'h03);
    for (int i = 0; i < NB; i++) hwrite(6'(16 + i), 8'h30 + 8'(i));
    hwrite(6'h07, 8'h03);

    for (int v = 0; v < 6; v++) begin
      logic [3:0] c; logic [4:0] l, cnt, el; logic [1:0] cd; logic [2:0] es;
      logic [7:0] seed;
      {c, l, cd, cnt, es, el} = VEC[v];
      seed = 8'hA0 + 8'(v * 16);
      hwrite(6'h00, {4'd0, c});
      hwrite(6'h01, 8'h50 + 8'(v));
      hwrite(6'h04, {3'd0, l});
      hwrite(6'h05, 8'h01);
      serve(cd, cnt, seed, 1'b0);
      chk($sformatf("R2 vec%0d req_cmd", v), {28'd0, cap_cmd}, {28'd0, c});
      chk($sformatf("R2 vec%0d req_len", v), {27'd0, cap_len}, {27'd0, l});
      chk($sformatf("R2 vec%0d req_addr", v), {12'd0, cap_addr}, {12'd0, 4'h3, 8'h12, 8'h50 + 8'(v)});
      if (!c[0]) begin
        for (int j = 0; j < int'(l); j++)
          chk($sformatf("R2 vec%0d payload byte %0d", v, j), {24'd0, cap_data[j*8 +: 8]},
              {24'd0, 8'h30 + 8'(j)});
      end
      hread(6'h06, rv); chk($sformatf("R4 R5 R6 vec%0d status", v), {24'd0, rv}, {29'd0, es});
      hread(6'h04, rv); chk($sformatf("R6 vec%0d count register", v), {24'd0, rv}, {27'd0, el});
      hread(6'h05, rv); chk($sformatf("R3 vec%0d start bit cleared", v), {24'd0, rv}, 32'h0);
      chk($sformatf("R7 vec%0d irq raised", v), {31'd0, irq}, 32'd1);
      if (c[0]) begin
        for (int j = 0; j < int'(cnt); j++) begin
          hread(6'(32 + j), rv);
          chk($sformatf("R4 vec%0d returned byte %0d", v, j), {24'd0, rv}, {24'd0, seed + 8'(j)});
        end
      end
      hwrite(6'h06, 8'h07);
      hread(6'h06, rv); chk($sformatf("R9 vec%0d status cleared", v), {24'd0, rv}, 32'h0);
      chk($sformatf("R7 vec%0d irq dropped", v), {31'd0, irq}, 32'd0);
    end

    // R4: byte 3 kept from the 16-byte read (vec2 seed C0) after the 3-byte short read
    hread(6'h23, rv); chk("R4 byte beyond short count untouched", {24'd0, rv}, 32'hC3);

    // R8: writes while busy ignored
    hwrite(6'h00, 8'h04);
    hwrite(6'h04, 8'd2);
    hwrite(6'h05, 8'h01);
    hwrite(6'h04, 8'd7);
    hwrite(6'h00, 8'h01);
    hwrite(6'h10, 8'hEE);
    hwrite(6'h01, 8'h99);
    serve(2'd0, 5'd2, 8'h00, 1'b0);
    chk("R8 req_len unchanged by busy write", {27'd0, cap_len}, 32'd2);
    chk("R8 req_cmd unchanged by busy write", {28'd0, cap_cmd}, 32'h4);
    chk("R8 payload unchanged by busy write", {24'd0, cap_data[7:0]}, 32'h30);
    hread(6'h04, rv); chk("R8 count register after busy write", {24'd0, rv}, 32'd2);
    hread(6'h10, rv); chk("R8 payload byte0 after busy write", {24'd0, rv}, 32'h30);
    hread(6'h01, rv); chk("R8 address after busy write", {24'd0, rv}, 32'h55);
    repeat (4) @(negedge clk);
    chk("R3 single request per start", {31'd0, req_valid}, 32'd0);
    hwrite(6'h06, 8'h07);

    // R7 gating
    hwrite(6'h07, 8'h01);
    hwrite(6'h05, 8'h01);
    serve(2'd0, 5'd2, 8'h00, 1'b0);
    chk("R7 irq held low without global enable", {31'd0, irq}, 32'd0);
    hwrite(6'h07, 8'h03);
    chk("R7 irq with both enables", {31'd0, irq}, 32'd1);
    hwrite(6'h07, 8'h02);
    chk("R7 irq held low without source enable", {31'd0, irq}, 32'd0);
    hwrite(6'h06, 8'h07);

    // R9 set wins over same-cycle clear; R5 address NACK on a write
    hwrite(6'h05, 8'h01);
    serve(2'd1, 5'd0, 8'h00, 1'b1);
    hread(6'h06, rv); chk("R9 R5 flags set despite same-cycle clear", {24'd0, rv}, 32'h3);
    hread(6'h04, rv); chk("R5 count kept after address NACK", {24'd0, rv}, 32'd2);
    hwrite(6'h06, 8'h02);
    hread(6'h06, rv); chk("R9 clear only the written bit", {24'd0, rv}, 32'h1);

    finish_run();
  end

endmodule